// File: doc/BRIEF.md
# Threshold Trim Command Decoder

This block watches the byte-level output of a serial-bus slave front end and recognises the one write transaction that asks for a voltage trip threshold to be trimmed. A transaction is framed by START and STOP strobes, and in between it carries a slave identifier, a byte address that names the threshold and the kind of trim, and a data byte. A level input, `prog_en_i`, stands for a programming voltage being present on a shared pin. A command counts only if that level is already high when START arrives, and only if it stays high until the transaction's STOP.

After a well-formed command is closed by STOP, the block goes busy and holds the operation pending. It completes when the programming level is removed, and at that point it emits a single-cycle pulse on the matching set or reset output. A set can only raise a threshold. To lower a threshold, a reset command must come first and a set command after it. Any malformed or unqualified transaction is dropped silently.

The controller is one finite state machine with these states:
- IDLE
- SLAVE: waiting for the identifier byte
- ADDR: waiting for the byte address
- DATA: waiting for the data byte
- STOPW: waiting for STOP
- SKIP: discarding the rest of a rejected transaction
- PROG: busy

It has these transitions:
- start-qualified: IDLE/collecting/SKIP to SLAVE
- start-unqualified: to SKIP
- byte-accepted: SLAVE to ADDR to DATA to STOPW
- byte-rejected, extra byte or enable lost: to SKIP
- stop-commit: STOPW to PROG
- stop-abort: any other non-busy state to IDLE
- complete: PROG to IDLE when the enable drops

Top module: `trip_trim_decoder`

## Requirements
- R1: After reset, busy_o is low and every pulse output is low.
- R2: With prog_en_i high at START, the byte sequence A0h, a valid byte address and 00h, followed by STOP, raises busy_o in the cycle after the STOP strobe. busy_o then stays high while prog_en_i stays high.
- R3: The byte address selects the operation. 01h is a set of threshold 1 and 09h is a set of threshold 2. 03h is a reset of threshold 1 and 0Bh is a reset of threshold 2. Bit 0 of set_pulse_o and rst_pulse_o is threshold 1, and bit 1 is threshold 2.
- R4: A transaction whose START arrives while prog_en_i is low produces no busy and no pulse, even if the enable rises later in that transaction.
- R5: An identifier byte other than A0h aborts the transaction with no busy and no pulse.
- R6: A byte address other than the four listed in R3 aborts the transaction with no busy and no pulse.
- R7: A data byte other than 00h, or any byte received after the data byte, aborts the transaction with no busy and no pulse.
- R8: If prog_en_i falls at any point between START and STOP, the transaction is aborted with no busy and no pulse.
- R9: A STOP that arrives before all three bytes have been received returns the block to idle with no busy and no pulse.
- R10: While busy, START, bytes and STOP have no effect. The pulse for the pending command appears in the cycle after the first clock edge that samples prog_en_i low, and busy_o falls in that same cycle.
- R11: Each completed command gives exactly one pulse, one cycle wide, on exactly one of the four pulse lines.
- R12: A START in the middle of a transaction discards the bytes received so far and begins capture afresh, re-checking prog_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle strobe: START seen on the bus |
| stop_i | input | 1 | One-cycle strobe: STOP seen on the bus |
| byte_valid_i | input | 1 | One-cycle strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received byte |
| prog_en_i | input | 1 | Programming-voltage present level |
| set_pulse_o | output | 2 | One-cycle set pulse, bit 0 = threshold 1 |
| rst_pulse_o | output | 2 | One-cycle reset pulse, bit 0 = threshold 1 |
| busy_o | output | 1 | Programming operation pending |

## Verification
The assertions watch the following on every cycle:
- the pulse lines are never active together;
- a pulse is never wider than one cycle;
- a pulse only follows a busy cycle that sampled the enable low;
- busy only rises after a STOP;
- the pending state is held while the enable stays high.

Other behaviour can only be shown by the bench's scenarios, which run against a behavioural reference model. These cover:
- the mapping of each byte address to its pulse line;
- silent rejection of wrong identifiers, addresses, data, extra bytes, an unqualified START and a lost enable;
- restart on a repeated START;
- the fact that a second command sent while busy cannot replace the pending operation.

// File: rtl/trim_pkg.sv
package trim_pkg;

    // Number of trimmable thresholds and width of the selector
    localparam int NUM_THR = 2;
    localparam int THR_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLAVE,
        ST_ADDR,
        ST_DATA,
        ST_STOPW,
        ST_SKIP,
        ST_PROG
    } trim_state_e;

    typedef struct packed {
        logic             is_reset;
        logic [THR_W-1:0] sel;
    } trim_op_t;

endpackage

// File: rtl/trim_cmd_match.sv
module trim_cmd_match
    import trim_pkg::*;
#(
    parameter logic [7:0]           SLAVE_ID  = 8'hA0,
    parameter logic [7:0]           DATA_REQ  = 8'h00,
    parameter logic [NUM_THR*8-1:0] SET_ADDRS = {8'h09, 8'h01},
    parameter logic [NUM_THR*8-1:0] RST_ADDRS = {8'h0B, 8'h03}
) (
    input  logic [7:0] byte_i,
    output logic       slave_ok_o,
    output logic       addr_ok_o,
    output logic       data_ok_o,
    output trim_op_t   op_o
);

    logic [NUM_THR-1:0] set_hit;
    logic [NUM_THR-1:0] rst_hit;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_addr_cmp
        assign set_hit[t] = (byte_i == SET_ADDRS[t*8 +: 8]);
        assign rst_hit[t] = (byte_i == RST_ADDRS[t*8 +: 8]);
    end

    assign slave_ok_o = (byte_i == SLAVE_ID);
    assign data_ok_o  = (byte_i == DATA_REQ);
    assign addr_ok_o  = (|set_hit) | (|rst_hit);

    always_comb begin
        op_o.is_reset = |rst_hit;
        op_o.sel      = '0;
        for (int t = 0; t < NUM_THR; t++) begin
            if (set_hit[t] || rst_hit[t]) begin
                op_o.sel = THR_W'(t);
            end
        end
    end

endmodule

// File: rtl/trim_seq_fsm.sv
module trim_seq_fsm
    import trim_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic        byte_valid_i,
    input  logic        prog_en_i,
    input  logic        slave_ok_i,
    input  logic        addr_ok_i,
    input  logic        data_ok_i,
    input  trim_op_t    op_i,
    output trim_state_e state_o,
    output trim_op_t    op_o,
    output logic        fire_o
);

    trim_state_e state_q, state_d;
    trim_op_t    op_q;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Operation latch: captured when the byte address is accepted
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            op_q <= '0;
        end else if (state_q == ST_ADDR && byte_valid_i && addr_ok_i
                     && prog_en_i && !start_i && !stop_i) begin
            op_q <= op_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PROG: begin
                if (!prog_en_i) state_d = ST_IDLE;
            end
            ST_IDLE, ST_SKIP: begin
                if (start_i)     state_d = prog_en_i ? ST_SLAVE : ST_SKIP;
                else if (stop_i) state_d = ST_IDLE;
            end
            ST_SLAVE: begin
                if (start_i)           state_d = prog_en_i ? ST_SLAVE : ST_SKIP;
                else if (stop_i)       state_d = ST_IDLE;
                else if (!prog_en_i)   state_d = ST_SKIP;
                else if (byte_valid_i) state_d = slave_ok_i ? ST_ADDR : ST_SKIP;
            end
            ST_ADDR: begin
                if (start_i)           state_d = prog_en_i ? ST_SLAVE : ST_SKIP;
                else if (stop_i)       state_d = ST_IDLE;
                else if (!prog_en_i)   state_d = ST_SKIP;
                else if (byte_valid_i) state_d = addr_ok_i ? ST_DATA : ST_SKIP;
            end
            ST_DATA: begin
                if (start_i)           state_d = prog_en_i ? ST_SLAVE : ST_SKIP;
                else if (stop_i)       state_d = ST_IDLE;
                else if (!prog_en_i)   state_d = ST_SKIP;
                else if (byte_valid_i) state_d = data_ok_i ? ST_STOPW : ST_SKIP;
            end
            ST_STOPW: begin
                if (start_i)           state_d = prog_en_i ? ST_SLAVE : ST_SKIP;
                else if (stop_i)       state_d = ST_PROG;
                else if (!prog_en_i)   state_d = ST_SKIP;
                else if (byte_valid_i) state_d = ST_SKIP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
    assign op_o    = op_q;
    assign fire_o  = (state_q == ST_PROG) && !prog_en_i;

    // R10
    prog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PROG && prog_en_i) |=> (state_q == ST_PROG));

    // R2
    prog_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_PROG && state_d == ST_PROG) |-> (state_q == ST_STOPW && stop_i));

endmodule

// File: rtl/trim_pulse_gen.sv
module trim_pulse_gen
    import trim_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               fire_i,
    input  trim_op_t           op_i,
    output logic [NUM_THR-1:0] set_o,
    output logic [NUM_THR-1:0] rst_o
);

    for (genvar t = 0; t < NUM_THR; t++) begin : g_pulse
        logic set_q, rst_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                set_q <= 1'b0;
                rst_q <= 1'b0;
            end else begin
                set_q <= fire_i && !op_i.is_reset && (op_i.sel == THR_W'(t));
                rst_q <= fire_i &&  op_i.is_reset && (op_i.sel == THR_W'(t));
            end
        end
        assign set_o[t] = set_q;
        assign rst_o[t] = rst_q;
    end

    // R11
    pulse_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({set_o, rst_o}));

    // R11
    pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|{set_o, rst_o}) |=> !(|{set_o, rst_o}));

endmodule

// File: rtl/trip_trim_decoder.sv
module trip_trim_decoder
    import trim_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                byte_valid_i,
    input  logic [7:0]          byte_i,
    input  logic                prog_en_i,
    output logic [NUM_THR-1:0]  set_pulse_o,
    output logic [NUM_THR-1:0]  rst_pulse_o,
    output logic                busy_o
);

    logic        slave_ok, addr_ok, data_ok, fire;
    trim_op_t    op_dec, op_held;
    trim_state_e state;

    trim_cmd_match u_match (
        .byte_i     (byte_i),
        .slave_ok_o (slave_ok),
        .addr_ok_o  (addr_ok),
        .data_ok_o  (data_ok),
        .op_o       (op_dec)
    );

    trim_seq_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .byte_valid_i (byte_valid_i),
        .prog_en_i    (prog_en_i),
        .slave_ok_i   (slave_ok),
        .addr_ok_i    (addr_ok),
        .data_ok_i    (data_ok),
        .op_i         (op_dec),
        .state_o      (state),
        .op_o         (op_held),
        .fire_o       (fire)
    );

    trim_pulse_gen u_pulse (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .fire_i (fire),
        .op_i   (op_held),
        .set_o  (set_pulse_o),
        .rst_o  (rst_pulse_o)
    );

    assign busy_o = (state == ST_PROG);

    // R10
    pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|{set_pulse_o, rst_pulse_o}) |-> ($past(busy_o) && !$past(prog_en_i)));

    // R2
    busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(stop_i));

    // R10
    busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (!$past(prog_en_i) && (|{set_pulse_o, rst_pulse_o})));

endmodule

// File: tb/trip_trim_decoder_tb_top.sv
module trip_trim_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, stop = 1'b0, bv = 1'b0, pen = 1'b0;
    logic [7:0] bdat = 8'h00;
    logic [1:0] set_p, rst_p;
    logic       busy;

    always #4 clk = ~clk;   // 125 MHz

    trip_trim_decoder dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
        .byte_valid_i(bv), .byte_i(bdat), .prog_en_i(pen),
        .set_pulse_o(set_p), .rst_pulse_o(rst_p), .busy_o(busy)
    );

    int    checks = 0, errors = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    int         m_phase = 0;       // 0 idle, 1 collecting, 2 discarding, 3 busy
    logic [7:0] m_q[$];
    int         m_op = 0;          // 0 set1, 1 set2, 2 rst1, 3 rst2
    logic [1:0] e_set = 0, e_rst = 0;
    logic       e_busy = 0;

    function automatic int addr_code(input logic [7:0] a);
        case (a)
            8'h01: return 0;
            8'h09: return 1;
            8'h03: return 2;
            8'h0B: return 3;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_q.delete(); e_set = 0; e_rst = 0;
        end else begin
            e_set = 0; e_rst = 0;
            if (m_phase == 3) begin
                if (!pen) begin
                    if (m_op < 2) e_set[m_op] = 1'b1;
                    else          e_rst[m_op-2] = 1'b1;
                    m_phase = 0;
                end
            end else if (start) begin
                m_q.delete();
                m_phase = pen ? 1 : 2;
            end else if (stop) begin
                if (m_phase == 1 && m_q.size() == 3 && m_q[0] == 8'hA0
                    && addr_code(m_q[1]) >= 0 && m_q[2] == 8'h00) begin
                    m_op = addr_code(m_q[1]);
                    m_phase = 3;
                end else begin
                    m_phase = 0;
                end
            end else if (m_phase == 1 && !pen) begin
                m_phase = 2;
            end else if (m_phase == 1 && bv) begin
                m_q.push_back(bdat);
            end
        end
        e_busy = (m_phase == 3);
    end

    // Per-cycle comparison and pulse bookkeeping, away from the active edge
    int         pulse_cnt = 0;
    logic [3:0] last_pulse = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (set_p !== e_set || rst_p !== e_rst || busy !== e_busy) begin
                errors++;
                $display("FAIL %s: set=%b rst=%b busy=%b expected set=%b rst=%b busy=%b",
                         cur_req, set_p, rst_p, busy, e_set, e_rst, e_busy);
            end
            if (|{rst_p, set_p}) begin
                pulse_cnt++;
                last_pulse = {rst_p, set_p};
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk) start = 1; @(negedge clk) start = 0;
    endtask

    task automatic do_stop();
        @(negedge clk) stop = 1; @(negedge clk) stop = 0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk) begin bv = 1; bdat = b; end
        @(negedge clk) begin bv = 0; end
    endtask

    task automatic finish_prog();
        idle(3); @(negedge clk) pen = 0; idle(3);
    endtask

    task automatic begin_scn(input string tag);
        cur_req = tag; pulse_cnt = 0; last_pulse = 0;
    endtask

    // exp_vec bit layout: {rst2, rst1, set2, set1}
    task automatic end_scn(input int exp_cnt, input logic [3:0] exp_vec);
        checks++;
        if (pulse_cnt != exp_cnt || last_pulse !== exp_vec) begin
            errors++;
            $display("FAIL %s: pulses=%0d vec=%b expected pulses=%0d vec=%b",
                     cur_req, pulse_cnt, last_pulse, exp_cnt, exp_vec);
        end
    endtask

    task automatic full_cmd(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d);
        @(negedge clk) pen = 1;
        do_start(); send(s); send(a); send(d); do_stop();
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state
        checks++;
        if (busy !== 0 || set_p !== 0 || rst_p !== 0) begin
            errors++;
            $display("FAIL R1: busy=%b set=%b rst=%b expected all zero", busy, set_p, rst_p);
        end
        @(negedge clk) rst_n = 1;
        idle(2);

        // R2, R3: set threshold 1
        begin_scn("R2");
        full_cmd(8'h01, 8'hA0, 8'h00);
        checks++;
        if (busy !== 1) begin
            errors++; $display("FAIL R2: busy=%b expected 1", busy);
        end
        finish_prog(); end_scn(1, 4'b0001);

        begin_scn("R3 set2");   full_cmd(8'h09, 8'hA0, 8'h00); finish_prog(); end_scn(1, 4'b0010);
        begin_scn("R3 rst1");   full_cmd(8'h03, 8'hA0, 8'h00); finish_prog(); end_scn(1, 4'b0100);
        begin_scn("R3 rst2 R11"); full_cmd(8'h0B, 8'hA0, 8'h00); finish_prog(); end_scn(1, 4'b1000);

        // R4: enable raised only after START
        begin_scn("R4");
        @(negedge clk) pen = 0;
        do_start(); @(negedge clk) pen = 1;
        send(8'hA0); send(8'h01); send(8'h00); do_stop();
        finish_prog(); end_scn(0, 4'b0000);

        begin_scn("R5");  full_cmd(8'h01, 8'hA2, 8'h00); finish_prog(); end_scn(0, 4'b0000);
        begin_scn("R6");  full_cmd(8'h05, 8'hA0, 8'h00); finish_prog(); end_scn(0, 4'b0000);
        begin_scn("R7 data"); full_cmd(8'h09, 8'hA0, 8'h01); finish_prog(); end_scn(0, 4'b0000);

        begin_scn("R7 extra");
        @(negedge clk) pen = 1;
        do_start(); send(8'hA0); send(8'h03); send(8'h00); send(8'h00); do_stop();
        finish_prog(); end_scn(0, 4'b0000);

        // R8: enable lost mid-transaction, restored before STOP
        begin_scn("R8");
        @(negedge clk) pen = 1;
        do_start(); send(8'hA0); send(8'h01);
        @(negedge clk) pen = 0; @(negedge clk) pen = 1;
        send(8'h00); do_stop();
        finish_prog(); end_scn(0, 4'b0000);

        // R9: early STOP
        begin_scn("R9");
        @(negedge clk) pen = 1;
        do_start(); send(8'hA0); send(8'h09); do_stop();
        finish_prog(); end_scn(0, 4'b0000);

        // R10: traffic while busy is ignored
        begin_scn("R10");
        full_cmd(8'h09, 8'hA0, 8'h00);
        do_start(); send(8'hA0); send(8'h0B); send(8'h00); do_stop();
        idle(2);
        checks++;
        if (busy !== 1 || pulse_cnt != 0) begin
            errors++;
            $display("FAIL R10: busy=%b pulses=%0d expected busy=1 pulses=0", busy, pulse_cnt);
        end
        finish_prog(); end_scn(1, 4'b0010);

        // R12: repeated START restarts capture
        begin_scn("R12");
        @(negedge clk) pen = 1;
        do_start(); send(8'hA0);
        do_start(); send(8'hA0); send(8'h03); send(8'h00); do_stop();
        finish_prog(); end_scn(1, 4'b0100);

        // R12: repeated START with enable low rejects
        begin_scn("R12 unq");
        @(negedge clk) pen = 1;
        do_start(); send(8'hA0); send(8'h01);
        @(negedge clk) pen = 0;
        do_start(); @(negedge clk) pen = 1;
        send(8'hA0); send(8'h01); send(8'h00); do_stop();
        finish_prog(); end_scn(0, 4'b0000);

        idle(4);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule